// File: doc/BRIEF.md
# Width-split function unit allocator

This block hands out function unit slots to incoming operations of 8, 16, 32 or 64 bits. The slots come in only two native sizes: a pool of 32-bit units and a pool of 8-bit units. Each unit has its own busy bit. The two wider-than-native widths are built from pairs. A 64-bit operation takes two neighbouring 32-bit units. A 16-bit operation takes two neighbouring 8-bit units. A pair always starts on an even index: the even unit carries the upper half and the odd unit carries the lower half.

For each request, the block looks at the current busy bits in the same cycle. It grants the lowest-indexed free group of the right shape. If no such group exists, it raises a stall instead. A unit, or a whole pair, is returned through a release port. A small operand-gather mux rebuilds the full-width operand for the ALU. For a paired operation it concatenates the values held by both units of the pair.

Top module: `fu_alloc_split`

## Requirements
- R1: After reset every unit in both pools is free: `busy_wide` and `busy_narrow` are zero, and with no request `stall` and both grant masks are zero.
- R2: `req_width` encodes the width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. An 8-bit request is granted the single lowest-indexed free 8-bit unit on `gnt_narrow_mask`. A 32-bit request is granted the single lowest-indexed free 32-bit unit on `gnt_wide_mask`. The grant appears in the same cycle as the request, and the other pool's mask stays zero.
- R3: A 16-bit request is granted two 8-bit units 2k and 2k+1. The pair chosen is the lowest k with both units free. A free unit whose partner in its aligned pair is busy is never used, so a misaligned pair is never granted.
- R4: A 64-bit request is granted the lowest aligned pair 2k, 2k+1 of free 32-bit units on `gnt_wide_mask`.
- R5: When `req_valid` is high and no free group of the requested shape exists, `stall` is high in that cycle, both grant masks are zero, and the busy bits do not change.
- R6: The units named in a grant read busy from the next clock edge onward. For a pair, both bits are set at the same edge.
- R7: A release (`rel_valid`, pool chosen by `rel_narrow`, unit `rel_idx`) frees the named unit at the next edge. If that unit belongs to a granted pair, naming either unit of the pair frees both together. Releasing a unit that is already free has no effect.
- R8: The gather output for a 32-bit width is the addressed 32-bit unit's value, zero-extended to 64 bits. For a 64-bit width it is {value of unit 2k, value of unit 2k+1}, where k is `gth_idx` with bit 0 ignored.
- R9: The gather output for an 8-bit width is the addressed byte unit's value, zero-extended. For a 16-bit width it is {byte of unit 2k, byte of unit 2k+1}, zero-extended.
- R10: A 64-bit request stalls whenever no aligned pair is fully free, even if several isolated 32-bit units are free. A 32-bit request in the same state is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An operation asks for units this cycle |
| req_width | input | 2 | Operation width code (0=8, 1=16, 2=32, 3=64) |
| rel_valid | input | 1 | Release one unit or pair this cycle |
| rel_narrow | input | 1 | Release targets the 8-bit pool when high, else the 32-bit pool |
| rel_idx | input | IDX_W | Index of the unit to release |
| wide_val | input | N_UNITS*WORD_W | Operand values held by the 32-bit units, unit 0 in the low bits |
| narrow_val | input | N_UNITS*BYTE_W | Operand values held by the 8-bit units, unit 0 in the low bits |
| gth_width | input | 2 | Width code for the operand gather |
| gth_idx | input | IDX_W | Unit index for the operand gather |
| gnt_wide_mask | output | N_UNITS | 32-bit units granted this cycle |
| gnt_narrow_mask | output | N_UNITS | 8-bit units granted this cycle |
| stall | output | 1 | Request cannot be served this cycle |
| busy_wide | output | N_UNITS | Busy bits of the 32-bit pool |
| busy_narrow | output | N_UNITS | Busy bits of the 8-bit pool |
| gth_data | output | 2*WORD_W | Gathered operand for the ALU |

## Verification
Several properties are checked on every clock. A grant never names a busy unit. A pair grant always covers exactly one even/odd aligned couple. A stall never comes with a grant. Granted units read busy on the next edge. Both units of a recorded pair stay busy together. Only one pool grants in a given cycle. The bench's scenarios are what show the lowest-index choice, and that a lone free unit next to a busy partner is skipped. They also show that releasing either half frees the whole pair, that a release of an idle unit changes nothing, that 64-bit requests stall on a fragmented pool that still serves 32-bit ones, and that the gathered operands come out in the right order.

// File: rtl/fu_split_pkg.sv
package fu_split_pkg;

  typedef enum logic [1:0] {
    OPW_8  = 2'd0,
    OPW_16 = 2'd1,
    OPW_32 = 2'd2,
    OPW_64 = 2'd3
  } op_width_e;

endpackage

// File: rtl/fu_pick.sv
// Lowest-index finder over a free vector, either single units or aligned pairs.
module fu_pick #(
  parameter int N    = 8,
  parameter bit PAIR = 1'b0
) (
  input  logic [N-1:0] free_i,
  output logic         found_o,
  output logic [N-1:0] mask_o
);

  localparam int NP = N / 2;

  generate
    if (PAIR) begin : g_pair
      logic [NP-1:0] cand;
      for (genvar k = 0; k < NP; k++) begin : g_cand
        assign cand[k] = free_i[2*k] & free_i[2*k+1];
      end
      always_comb begin
        found_o = 1'b0;
        mask_o  = '0;
        for (int k = 0; k < NP; k++) begin
          if (cand[k] && !found_o) begin
            found_o       = 1'b1;
            mask_o[2*k]   = 1'b1;
            mask_o[2*k+1] = 1'b1;
          end
        end
      end
    end else begin : g_single
      always_comb begin
        found_o = 1'b0;
        mask_o  = '0;
        for (int i = 0; i < N; i++) begin
          if (free_i[i] && !found_o) begin
            found_o   = 1'b1;
            mask_o[i] = 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fu_pool.sv
// One pool of equal-size units with busy bits and pair bookkeeping.
module fu_pool #(
  parameter int N    = 8,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_one_i,
  input  logic          req_pair_i,
  input  logic          rel_valid_i,
  input  logic [IW-1:0] rel_idx_i,
  output logic [N-1:0]  gnt_mask_o,
  output logic          no_room_o,
  output logic [N-1:0]  busy_o
);

  localparam int NP = N / 2;

  function automatic logic [N-1:0] even_bits();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction
  localparam logic [N-1:0] EVEN_BITS = even_bits();

  logic [N-1:0]  busy_q, busy_d;
  logic [NP-1:0] paired_q, paired_d;
  logic [N-1:0]  free_v;
  logic [N-1:0]  one_mask, pair_mask, rel_mask;
  logic          one_found, pair_found;
  logic          upd_en;

  assign free_v = ~busy_q;

  fu_pick #(.N(N), .PAIR(1'b0)) i_pick_one (
    .free_i (free_v),
    .found_o(one_found),
    .mask_o (one_mask)
  );

  fu_pick #(.N(N), .PAIR(1'b1)) i_pick_pair (
    .free_i (free_v),
    .found_o(pair_found),
    .mask_o (pair_mask)
  );

  // grant selection
  always_comb begin
    gnt_mask_o = '0;
    if (req_pair_i && pair_found)     gnt_mask_o = pair_mask;
    else if (req_one_i && one_found)  gnt_mask_o = one_mask;
  end

  assign no_room_o = (req_pair_i && !pair_found) || (req_one_i && !one_found);

  // release decode: a unit of a recorded pair frees its partner too
  always_comb begin
    rel_mask = '0;
    if (rel_valid_i && busy_q[rel_idx_i]) begin
      if (paired_q[rel_idx_i[IW-1:1]]) begin
        rel_mask[{rel_idx_i[IW-1:1], 1'b0}] = 1'b1;
        rel_mask[{rel_idx_i[IW-1:1], 1'b1}] = 1'b1;
      end else begin
        rel_mask[rel_idx_i] = 1'b1;
      end
    end
  end

  // next state
  assign upd_en = req_one_i || req_pair_i || rel_valid_i;
  assign busy_d = (busy_q | gnt_mask_o) & ~rel_mask;

  generate
    for (genvar k = 0; k < NP; k++) begin : g_pairbit
      assign paired_d[k] = (paired_q[k] | (req_pair_i & gnt_mask_o[2*k]))
                         & ~(paired_q[k] & rel_mask[2*k]);
    end
  endgenerate

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      paired_q <= '0;
    end else if (upd_en) begin
      busy_q   <= busy_d;
      paired_q <= paired_d;
    end
  end

  assign busy_o = busy_q;

  p_grant_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_mask_o & busy_q) == '0)
    else $error("grant names a busy unit");

  p_pair_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pair_i && gnt_mask_o != '0) |->
      ($countones(gnt_mask_o) == 2 &&
       ((gnt_mask_o & EVEN_BITS) << 1) == (gnt_mask_o & ~EVEN_BITS)))
    else $error("pair grant not an aligned couple");

  p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    no_room_o |-> gnt_mask_o == '0)
    else $error("grant while out of room");

  p_busy_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_mask_o != '0) |=> ((busy_q & $past(gnt_mask_o)) == $past(gnt_mask_o)))
    else $error("granted unit not busy next cycle");

  generate
    for (genvar k = 0; k < NP; k++) begin : g_pair_chk
      p_pair_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        paired_q[k] |-> (busy_q[2*k] && busy_q[2*k+1]))
        else $error("pair halves out of step");
    end
  endgenerate

endmodule

// File: rtl/fu_gather.sv
// Rebuilds the ALU operand from one unit or from both halves of a pair.
module fu_gather
  import fu_split_pkg::*;
#(
  parameter int N      = 8,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int IW     = $clog2(N)
) (
  input  logic [1:0]          width_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [N*WORD_W-1:0] wide_val_i,
  input  logic [N*BYTE_W-1:0] narrow_val_i,
  output logic [2*WORD_W-1:0] data_o
);

  logic [IW-1:0] idx_hi, idx_lo;
  assign idx_hi = {idx_i[IW-1:1], 1'b0};
  assign idx_lo = {idx_i[IW-1:1], 1'b1};

  always_comb begin
    data_o = '0;
    case (op_width_e'(width_i))
      OPW_64: begin
        data_o[2*WORD_W-1:WORD_W] = wide_val_i[int'(idx_hi)*WORD_W +: WORD_W];
        data_o[WORD_W-1:0]        = wide_val_i[int'(idx_lo)*WORD_W +: WORD_W];
      end
      OPW_32: data_o[WORD_W-1:0] = wide_val_i[int'(idx_i)*WORD_W +: WORD_W];
      OPW_16: begin
        data_o[2*BYTE_W-1:BYTE_W] = narrow_val_i[int'(idx_hi)*BYTE_W +: BYTE_W];
        data_o[BYTE_W-1:0]        = narrow_val_i[int'(idx_lo)*BYTE_W +: BYTE_W];
      end
      default: data_o[BYTE_W-1:0] = narrow_val_i[int'(idx_i)*BYTE_W +: BYTE_W];
    endcase
  end

endmodule

// File: rtl/fu_alloc_split.sv
module fu_alloc_split
  import fu_split_pkg::*;
#(
  parameter int N_UNITS = 8,
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int IDX_W   = $clog2(N_UNITS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_width,
  input  logic                        rel_valid,
  input  logic                        rel_narrow,
  input  logic [IDX_W-1:0]            rel_idx,
  input  logic [N_UNITS*WORD_W-1:0]   wide_val,
  input  logic [N_UNITS*BYTE_W-1:0]   narrow_val,
  input  logic [1:0]                  gth_width,
  input  logic [IDX_W-1:0]            gth_idx,
  output logic [N_UNITS-1:0]          gnt_wide_mask,
  output logic [N_UNITS-1:0]          gnt_narrow_mask,
  output logic                        stall,
  output logic [N_UNITS-1:0]          busy_wide,
  output logic [N_UNITS-1:0]          busy_narrow,
  output logic [2*WORD_W-1:0]         gth_data
);

  op_width_e rw;
  logic      w_one, w_pair, n_one, n_pair;
  logic      w_no_room, n_no_room;

  assign rw     = op_width_e'(req_width);
  assign n_one  = req_valid && (rw == OPW_8);
  assign n_pair = req_valid && (rw == OPW_16);
  assign w_one  = req_valid && (rw == OPW_32);
  assign w_pair = req_valid && (rw == OPW_64);

  fu_pool #(.N(N_UNITS), .IW(IDX_W)) i_pool_wide (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_one_i  (w_one),
    .req_pair_i (w_pair),
    .rel_valid_i(rel_valid && !rel_narrow),
    .rel_idx_i  (rel_idx),
    .gnt_mask_o (gnt_wide_mask),
    .no_room_o  (w_no_room),
    .busy_o     (busy_wide)
  );

  fu_pool #(.N(N_UNITS), .IW(IDX_W)) i_pool_narrow (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_one_i  (n_one),
    .req_pair_i (n_pair),
    .rel_valid_i(rel_valid && rel_narrow),
    .rel_idx_i  (rel_idx),
    .gnt_mask_o (gnt_narrow_mask),
    .no_room_o  (n_no_room),
    .busy_o     (busy_narrow)
  );

  assign stall = w_no_room || n_no_room;

  fu_gather #(.N(N_UNITS), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .IW(IDX_W)) i_gather (
    .width_i     (gth_width),
    .idx_i       (gth_idx),
    .wide_val_i  (wide_val),
    .narrow_val_i(narrow_val),
    .data_o      (gth_data)
  );

  p_one_pool_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|gnt_wide_mask, |gnt_narrow_mask}))
    else $error("both pools granted at once");

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!stall && gnt_wide_mask == '0 && gnt_narrow_mask == '0))
    else $error("activity without a request");

endmodule

// File: tb/test_fu_alloc_split.sv
module test_fu_alloc_split;

  localparam int N  = 8;
  localparam int WW = 32;
  localparam int BW = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [1:0]      req_width;
  logic            rel_valid;
  logic            rel_narrow;
  logic [IW-1:0]   rel_idx;
  logic [N*WW-1:0] wide_val;
  logic [N*BW-1:0] narrow_val;
  logic [1:0]      gth_width;
  logic [IW-1:0]   gth_idx;
  logic [N-1:0]    gnt_wide_mask, gnt_narrow_mask, busy_wide, busy_narrow;
  logic            stall;
  logic [2*WW-1:0] gth_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [N-1:0] w;
    logic [N-1:0] n;
    logic         st;
    string        rq;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  fu_alloc_split #(.N_UNITS(N), .WORD_W(WW), .BYTE_W(BW)) i_fu_alloc_split (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_width(req_width),
    .rel_valid(rel_valid), .rel_narrow(rel_narrow), .rel_idx(rel_idx),
    .wide_val(wide_val), .narrow_val(narrow_val),
    .gth_width(gth_width), .gth_idx(gth_idx),
    .gnt_wide_mask(gnt_wide_mask), .gnt_narrow_mask(gnt_narrow_mask),
    .stall(stall), .busy_wide(busy_wide), .busy_narrow(busy_narrow),
    .gth_data(gth_data)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  // driver: one request per cycle, expected grant pushed to the scoreboard
  task automatic issue(logic [1:0] wd, logic [N-1:0] ew, logic [N-1:0] en,
                       logic est, string rq);
    exp_t it;
    @(posedge clk); #1;
    req_valid = 1'b1; req_width = wd; rel_valid = 1'b0;
    it.w = ew; it.n = en; it.st = est; it.rq = rq;
    sb.push_back(it);
  endtask

  task automatic release_unit(logic nar, logic [IW-1:0] idx);
    @(posedge clk); #1;
    req_valid = 1'b0; rel_valid = 1'b1; rel_narrow = nar; rel_idx = idx;
  endtask

  task automatic check_busy(logic [N-1:0] ew, logic [N-1:0] en, string rq);
    @(posedge clk); #1;
    req_valid = 1'b0; rel_valid = 1'b0;
    @(negedge clk);
    chk({rq, " busy_wide"},   64'(busy_wide),   64'(ew));
    chk({rq, " busy_narrow"}, 64'(busy_narrow), 64'(en));
  endtask

  // monitor: compare grants while the request is on the pins
  always @(negedge clk) begin
    exp_t got;
    if (sb.size() != 0) begin
      got = sb.pop_front();
      chk({got.rq, " wide grant"},   64'(gnt_wide_mask),   64'(got.w));
      chk({got.rq, " narrow grant"}, 64'(gnt_narrow_mask), 64'(got.n));
      chk({got.rq, " stall"},        64'(stall),           64'(got.st));
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_width = 2'd0;
    rel_valid = 1'b0; rel_narrow = 1'b0; rel_idx = '0;
    gth_width = 2'd0; gth_idx = '0;
    for (int i = 0; i < N; i++) begin
      wide_val[i*WW +: WW]   = 32'hA0B0_0000 + 32'(i * 17);
      narrow_val[i*BW +: BW] = 8'h10 + 8'(i * 3);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: everything free and quiet
    chk("R1 busy_wide",   64'(busy_wide),   64'h0);
    chk("R1 busy_narrow", 64'(busy_narrow), 64'h0);
    chk("R1 stall",       64'(stall),       64'h0);
    chk("R1 grants",      64'({gnt_wide_mask, gnt_narrow_mask}), 64'h0);

    // R2: single units, lowest index first
    issue(2'd0, 8'h00, 8'h01, 1'b0, "R2 byte#0");
    issue(2'd0, 8'h00, 8'h02, 1'b0, "R2 byte#1");
    issue(2'd2, 8'h01, 8'h00, 1'b0, "R2 word#0");
    check_busy(8'h01, 8'h03, "R6 after singles");

    // R3: byte pair skips pair 0 (busy)
    issue(2'd1, 8'h00, 8'h0C, 1'b0, "R3 pair");
    check_busy(8'h01, 8'h0F, "R6 after byte pair");
    release_unit(1'b1, 3'd0);
    check_busy(8'h01, 8'h0E, "R7 single release");
    issue(2'd1, 8'h00, 8'h30, 1'b0, "R3 misaligned unit 0 skipped");
    check_busy(8'h01, 8'h3E, "R6 byte pair 2");

    // R4: 64-bit pair
    issue(2'd3, 8'h0C, 8'h00, 1'b0, "R4 wide pair");
    check_busy(8'h0D, 8'h3E, "R6 wide pair");
    release_unit(1'b0, 3'd3);
    check_busy(8'h01, 8'h3E, "R7 pair release via lower half");
    release_unit(1'b0, 3'd5);
    check_busy(8'h01, 8'h3E, "R7 release of idle unit");

    // fill the wide pool with singles
    for (int i = 1; i < N; i++) issue(2'd2, 8'(1 << i), 8'h00, 1'b0, "R2 fill");
    check_busy(8'hFF, 8'h3E, "R6 wide full");

    // R5: stall, no grant, busy unchanged
    issue(2'd2, 8'h00, 8'h00, 1'b1, "R5 word stall");
    issue(2'd3, 8'h00, 8'h00, 1'b1, "R5 wide pair stall");
    check_busy(8'hFF, 8'h3E, "R5 busy held");

    // R10: fragmented pool
    release_unit(1'b0, 3'd2);
    release_unit(1'b0, 3'd5);
    check_busy(8'hDB, 8'h3E, "R7 two singles");
    issue(2'd3, 8'h00, 8'h00, 1'b1, "R10 fragmented 64-bit stall");
    issue(2'd2, 8'h04, 8'h00, 1'b0, "R10 32-bit still served");
    check_busy(8'hDF, 8'h3E, "R10 busy");

    // narrow pool to full
    issue(2'd1, 8'h00, 8'hC0, 1'b0, "R3 top pair");
    issue(2'd1, 8'h00, 8'h00, 1'b1, "R5 byte pair stall");
    issue(2'd0, 8'h00, 8'h01, 1'b0, "R2 lone byte");
    check_busy(8'hDF, 8'hFF, "R6 narrow full");

    // R8 / R9: operand gather
    gth_width = 2'd3; gth_idx = 3'd3; #1;
    chk("R8 gather 64 odd idx", gth_data, {wide_val[2*WW +: WW], wide_val[3*WW +: WW]});
    gth_idx = 3'd2; #1;
    chk("R8 gather 64 even idx", gth_data, {wide_val[2*WW +: WW], wide_val[3*WW +: WW]});
    gth_width = 2'd2; gth_idx = 3'd5; #1;
    chk("R8 gather 32", gth_data, {32'h0, wide_val[5*WW +: WW]});
    gth_width = 2'd1; gth_idx = 3'd5; #1;
    chk("R9 gather 16", gth_data, {48'h0, narrow_val[4*BW +: BW], narrow_val[5*BW +: BW]});
    gth_width = 2'd0; gth_idx = 3'd6; #1;
    chk("R9 gather 8", gth_data, {56'h0, narrow_val[6*BW +: BW]});

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule